// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit forms the data-memory addresses for a small DSP core. It holds four pointer registers (P0 to P3), a stack pointer, a signed offset register and one shared modifier register. Each cycle the core presents an addressing-mode code, a pointer select, a 16-bit displacement word and an optional dual-read request. The unit then returns one effective address, or two for a dual read. At the next clock edge it writes back any pointer that the mode post-modifies, using linear or modulo arithmetic.

The modifier register chooses modulo arithmetic for P0 and, if its top bit is set, for P1 as well. P2 and P3 always use linear arithmetic. A dual read takes its first address from the selected pointer and its second address from P3, which then steps up by one. A small register port loads any register and reads it back. A register write in the same cycle takes priority over an address update to that register.

Top module: `dsp_agu`

## Requirements
- R1: After reset, P0 to P3, the stack pointer and the offset register read 0x0000, and the modifier reads 0xFFFF.
- R2: Register codes on the write and read ports are 0 to 3 for P0 to P3, 4 for the stack pointer, 5 for the offset, 6 for the modifier and 7 for none. Code 7 reads 0. `rd_data_o` shows the selected register combinationally. A write lands at the clock edge and takes priority over a same-cycle address update of that register.
- R3: Mode codes are 0 for plain indirect, 1 for post-increment, 2 for post-decrement, 3 for post-offset, 4 for indexed-by-offset, 5 for indexed-by-displacement, 6 for stack pre-decrement and 7 for stack post-increment. In modes 0 to 3 the address is the selected pointer. In mode 4 it is pointer + offset, and in mode 5 it is pointer + `disp_i`, both modulo 2^16. Modes 0, 4 and 5 leave the pointer unchanged.
- R4: Modes 1, 2 and 3 output the old pointer and write back the pointer stepped by +1, -1 or the signed offset.
- R5: A modifier of 0xFFFF means linear arithmetic for every pointer. Any other value sets a modulus equal to its low 15 bits + 1. That modulus applies to P0, and to P1 only when bit 15 is 1.
- R6: Modulo update: let B be the smallest power of two at or above the modulus, with the buffer base at the pointer rounded down to a multiple of B. The step is added to the offset from the base. A sum above modulus-1 loses one modulus, and a negative sum gains one modulus, once.
- R7: P2 and P3 always update linearly, whatever the modifier holds.
- R8: A dual read with pointer select 0 to 2 and second select 3 outputs P3 on `ea2_o`, raises `ea2_valid_o`, and increments P3 by 1 linearly.
- R9: A dual read with pointer select 3, with a second select other than 3, or with a stack mode (6 or 7) raises `illegal_o`. It keeps both valids low and updates no pointer or stack pointer.
- R10: Mode 6 outputs SP-1 and leaves SP-1 in the stack pointer. Mode 7 outputs SP and leaves SP+1. Both are linear.
- R11: With `req_valid_i` low, no valid or illegal flag is raised and no register changes except through the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_valid_i | input | 1 | address request this cycle |
| mode_i | input | 3 | addressing-mode code |
| ptr_sel_i | input | 2 | pointer select, first address |
| disp_i | input | 16 | displacement word |
| dual_i | input | 1 | dual-read request |
| dual_sel_i | input | 2 | pointer select, second address |
| wr_en_i | input | 1 | register write enable |
| wr_addr_i | input | 3 | register write code |
| wr_data_i | input | 16 | register write data |
| rd_addr_i | input | 3 | register read code |
| rd_data_o | output | 16 | register read data |
| ea_o | output | 16 | first effective address |
| ea_valid_o | output | 1 | first address valid |
| ea2_o | output | 16 | second effective address |
| ea2_valid_o | output | 1 | second address valid |
| illegal_o | output | 1 | request rejected |

## Verification
The hardest case to reach is a modulo wrap. It needs the modifier programmed, and then P0 or P1 sitting at one edge of its aligned buffer while a post-modify step pushes it over that edge. Random pointers almost never land there. So directed sequences load the modifier and the pointer through the write port, right at the upper and lower bounds, and then apply increment, decrement and offset steps. The random phase draws the modifier from a small set of short moduli and keeps pointer stepping on P0 and P1 frequent, so that wraps recur. Every address and every read-back is compared with a bench model built from the requirements.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int AGU_AW = 16;

  typedef enum logic [2:0] {
    MD_IND  = 3'd0,
    MD_PINC = 3'd1,
    MD_PDEC = 3'd2,
    MD_POFF = 3'd3,
    MD_IDXN = 3'd4,
    MD_IDXD = 3'd5,
    MD_SPDEC = 3'd6,
    MD_SPINC = 3'd7
  } agu_mode_e;

  typedef enum logic [2:0] {
    RA_P0   = 3'd0,
    RA_P1   = 3'd1,
    RA_P2   = 3'd2,
    RA_P3   = 3'd3,
    RA_SP   = 3'd4,
    RA_OFF  = 3'd5,
    RA_MOD  = 3'd6,
    RA_NONE = 3'd7
  } agu_reg_e;
endpackage

// File: rtl/agu_step_calc.sv
module agu_step_calc #(
  parameter int AW     = 16,
  parameter bit MOD_EN = 1'b1
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  logic          mod_on_i,
  input  logic [AW-2:0] mod_i,
  output logic [AW-1:0] next_o
);
  localparam int SW = AW + 2;

  if (MOD_EN) begin : g_mod
    logic [AW-2:0]        mask;
    logic [AW-1:0]        base, off;
    logic signed [SW-1:0] sum, adj, mlim, mlen;

    always_comb begin
      for (int i = 0; i < AW - 1; i++) mask[i] = |(mod_i >> i);
      base = ptr_i & ~{1'b0, mask};
      off  = ptr_i & {1'b0, mask};
      mlim = $signed({3'b000, mod_i});
      mlen = mlim + SW'(1);
      sum  = $signed({2'b00, off}) + $signed({{2{step_i[AW-1]}}, step_i});
      if (sum > mlim)             adj = sum - mlen;
      else if (sum < SW'(0))      adj = sum + mlen;
      else                        adj = sum;
      next_o = mod_on_i ? (base + adj[AW-1:0]) : (ptr_i + step_i);
    end
  end else begin : g_lin
    logic unused_mod;
    assign unused_mod = ^{mod_on_i, mod_i};
    assign next_o = ptr_i + step_i;
  end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW   = 16,
  parameter int NPTR = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [2:0]               wr_addr_i,
  input  logic [AW-1:0]            wr_data_i,
  input  logic [NPTR-1:0]          upd_en_i,
  input  logic [NPTR-1:0][AW-1:0]  upd_val_i,
  input  logic                     sp_upd_en_i,
  input  logic [AW-1:0]            sp_upd_val_i,
  input  logic [2:0]               rd_addr_i,
  output logic [AW-1:0]            rd_data_o,
  output logic [NPTR-1:0][AW-1:0]  ptr_o,
  output logic [AW-1:0]            sp_o,
  output logic [AW-1:0]            off_o,
  output logic [AW-1:0]            mod_o
);
  import agu_pkg::*;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ptr_o[g] <= '0;
      else if (wr_en_i && wr_addr_i == 3'(g))       ptr_o[g] <= wr_data_i;
      else if (upd_en_i[g])                         ptr_o[g] <= upd_val_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_o  <= '0;
      off_o <= '0;
      mod_o <= '1;
    end else begin
      if (wr_en_i && wr_addr_i == RA_SP) sp_o <= wr_data_i;
      else if (sp_upd_en_i)              sp_o <= sp_upd_val_i;
      if (wr_en_i && wr_addr_i == RA_OFF) off_o <= wr_data_i;
      if (wr_en_i && wr_addr_i == RA_MOD) mod_o <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < 3'(NPTR))      rd_data_o = ptr_o[rd_addr_i[$clog2(NPTR)-1:0]];
    else if (rd_addr_i == RA_SP)   rd_data_o = sp_o;
    else if (rd_addr_i == RA_OFF)  rd_data_o = off_o;
    else if (rd_addr_i == RA_MOD)  rd_data_o = mod_o;
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == RA_OFF) |=> off_o == $past(wr_data_i));
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int AW   = 16,
  parameter int NPTR = 4,
  localparam int PSW = $clog2(NPTR)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [2:0]     mode_i,
  input  logic [PSW-1:0] ptr_sel_i,
  input  logic [AW-1:0]  disp_i,
  input  logic           dual_i,
  input  logic [PSW-1:0] dual_sel_i,
  input  logic           wr_en_i,
  input  logic [2:0]     wr_addr_i,
  input  logic [AW-1:0]  wr_data_i,
  input  logic [2:0]     rd_addr_i,
  output logic [AW-1:0]  rd_data_o,
  output logic [AW-1:0]  ea_o,
  output logic           ea_valid_o,
  output logic [AW-1:0]  ea2_o,
  output logic           ea2_valid_o,
  output logic           illegal_o
);
  import agu_pkg::*;

  localparam int LAST = NPTR - 1;

  logic [NPTR-1:0][AW-1:0] ptr_q;
  logic [AW-1:0]           sp_q, off_q, mod_q;
  logic [NPTR-1:0]         upd_en;
  logic [NPTR-1:0][AW-1:0] upd_val;
  logic                    sp_upd_en;
  logic [AW-1:0]           sp_upd_val;

  agu_mode_e     mode;
  logic          sp_mode, post_mod, legal, act, mod_on;
  logic [AW-1:0] sel_ptr, step, sel_next, last_next;

  agu_regfile #(.AW(AW), .NPTR(NPTR)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .upd_en_i(upd_en), .upd_val_i(upd_val),
    .sp_upd_en_i(sp_upd_en), .sp_upd_val_i(sp_upd_val),
    .rd_addr_i, .rd_data_o,
    .ptr_o(ptr_q), .sp_o(sp_q), .off_o(off_q), .mod_o(mod_q)
  );

  always_comb begin
    mode     = agu_mode_e'(mode_i);
    sp_mode  = (mode == MD_SPDEC) || (mode == MD_SPINC);
    post_mod = (mode == MD_PINC) || (mode == MD_PDEC) || (mode == MD_POFF);
    legal    = !dual_i ||
               (ptr_sel_i != PSW'(LAST) && dual_sel_i == PSW'(LAST) && !sp_mode);
    act      = req_valid_i && legal;
    sel_ptr  = ptr_q[ptr_sel_i];
    mod_on   = (mod_q != '1) &&
               (ptr_sel_i == '0 || (ptr_sel_i == PSW'(1) && mod_q[AW-1]));
    unique case (mode)
      MD_PINC: step = AW'(1);
      MD_PDEC: step = '1;
      MD_POFF: step = off_q;
      default: step = '0;
    endcase
  end

  agu_step_calc #(.AW(AW), .MOD_EN(1'b1)) u_sel_calc (
    .ptr_i(sel_ptr), .step_i(step), .mod_on_i(mod_on),
    .mod_i(mod_q[AW-2:0]), .next_o(sel_next)
  );

  // Second read pointer: linear only
  agu_step_calc #(.AW(AW), .MOD_EN(1'b0)) u_last_calc (
    .ptr_i(ptr_q[LAST]), .step_i(AW'(1)), .mod_on_i(1'b0),
    .mod_i('0), .next_o(last_next)
  );

  always_comb begin
    unique case (mode)
      MD_IDXN:  ea_o = sel_ptr + off_q;
      MD_IDXD:  ea_o = sel_ptr + disp_i;
      MD_SPDEC: ea_o = sp_q - AW'(1);
      MD_SPINC: ea_o = sp_q;
      default:  ea_o = sel_ptr;
    endcase
    ea_valid_o  = act;
    ea2_o       = ptr_q[LAST];
    ea2_valid_o = act && dual_i;
    illegal_o   = req_valid_i && !legal;

    for (int i = 0; i < NPTR; i++) begin
      upd_en[i]  = act && post_mod && (ptr_sel_i == PSW'(i));
      upd_val[i] = sel_next;
    end
    if (act && dual_i) begin
      upd_en[LAST]  = 1'b1;
      upd_val[LAST] = last_next;
    end
    sp_upd_en  = act && sp_mode;
    sp_upd_val = (mode == MD_SPDEC) ? sp_q - AW'(1) : sp_q + AW'(1);
  end

  // R9
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !wr_en_i) |=> ($stable(ptr_q) && $stable(sp_q)));

  // R9
  illegal_novalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !ea_valid_o && !ea2_valid_o);

  // R8
  dual_last_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ea2_valid_o && !wr_en_i) |=> ptr_q[LAST] == $past(ptr_q[LAST]) + AW'(1));

  // R3
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ea_valid_o && !dual_i && !wr_en_i &&
     (mode_i == MD_IND || mode_i == MD_IDXN || mode_i == MD_IDXD)) |=> $stable(ptr_q));

  // R10
  sp_predec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ea_valid_o && mode_i == MD_SPDEC && !wr_en_i) |=> sp_q == $past(ea_o));

  // R7
  p2_linear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ea_valid_o && mode_i == MD_PINC && ptr_sel_i == PSW'(2) && !wr_en_i)
      |=> ptr_q[2] == $past(ptr_q[2]) + AW'(1));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !wr_en_i) |=> ($stable(ptr_q) && $stable(sp_q)));
endmodule

// File: tb/dsp_agu_bench.sv
module dsp_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_v = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  psel = '0, dsel = '0;
  logic [15:0] disp = '0;
  logic        dual = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  wa = 3'd7, ra = 3'd7;
  logic [15:0] wd = '0;
  logic [15:0] rd, ea, ea2;
  logic        eav, ea2v, ill;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] mp [0:3];
  logic [15:0] msp, moff, mmod;

  always #5 clk = ~clk;

  dsp_agu u_dsp_agu (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .mode_i(mode),
    .ptr_sel_i(psel), .disp_i(disp), .dual_i(dual), .dual_sel_i(dsel),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra),
    .rd_data_o(rd), .ea_o(ea), .ea_valid_o(eav), .ea2_o(ea2),
    .ea2_valid_o(ea2v), .illegal_o(ill)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2, 3'd3: return mp[a[1:0]];
      3'd4: return msp;
      3'd5: return moff;
      3'd6: return mmod;
      default: return 16'h0000;
    endcase
  endfunction

  // Requirement-level modulo step
  function automatic logic [15:0] step_ptr(int idx, logic [15:0] r, logic [15:0] st);
    int modl, bsz, base, n;
    if (mmod == 16'hFFFF || idx > 1 || (idx == 1 && !mmod[15])) return r + st;
    modl = int'(mmod[14:0]) + 1;
    bsz = 1;
    while (bsz < modl) bsz = bsz * 2;
    base = int'(r) - (int'(r) % bsz);
    n = (int'(r) - base) + int'($signed(st));
    if (n > modl - 1) n = n - modl;
    else if (n < 0) n = n + modl;
    return 16'(base + n);
  endfunction

  task automatic cyc(bit v, logic [2:0] md, logic [1:0] ps, logic [15:0] dp,
                     bit du, logic [1:0] ds, bit w, logic [2:0] a,
                     logic [15:0] d, logic [2:0] r);
    bit legal, act;
    logic [15:0] exp_ea, st, nxt;
    logic [15:0] np [0:3];
    logic [15:0] nsp;
    @(negedge clk);
    req_v = v; mode = md; psel = ps; disp = dp; dual = du; dsel = ds;
    we = w; wa = a; wd = d; ra = r;
    #2;
    legal = !du || (ps != 2'd3 && ds == 2'd3 && md < 3'd6);
    act = v && legal;
    check("R2 read port", rd, model_rd(r));
    check("R9/R11 illegal flag", {15'd0, ill}, {15'd0, v && !legal});
    check("R9/R11 ea valid", {15'd0, eav}, {15'd0, act});
    check("R8 ea2 valid", {15'd0, ea2v}, {15'd0, act && du});
    case (md)
      3'd4: exp_ea = mp[ps] + moff;
      3'd5: exp_ea = mp[ps] + dp;
      3'd6: exp_ea = msp - 16'd1;
      3'd7: exp_ea = msp;
      default: exp_ea = mp[ps];
    endcase
    if (act) begin
      if (md >= 3'd6) check("R10 stack address", ea, exp_ea);
      else check("R3 effective address", ea, exp_ea);
      if (du) check("R8 second address", ea2, mp[3]);
    end
    for (int i = 0; i < 4; i++) np[i] = mp[i];
    nsp = msp;
    if (act) begin
      st = (md == 3'd1) ? 16'd1 : (md == 3'd2) ? 16'hFFFF : moff;
      if (md >= 3'd1 && md <= 3'd3) begin
        nxt = step_ptr(int'(ps), mp[ps], st);
        np[ps] = nxt;
      end
      if (du) np[3] = mp[3] + 16'd1;
      if (md == 3'd6) nsp = msp - 16'd1;
      if (md == 3'd7) nsp = msp + 16'd1;
    end
    if (w) begin
      if (a < 3'd4) np[a[1:0]] = d;
      else if (a == 3'd4) nsp = d;
      else if (a == 3'd5) moff = d;
      else if (a == 3'd6) mmod = d;
    end
    for (int i = 0; i < 4; i++) mp[i] = np[i];
    msp = nsp;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    cyc(0, 3'd0, 2'd0, 16'd0, 0, 2'd3, 1, a, d, 3'd7);
  endtask

  task automatic op(logic [2:0] md, logic [1:0] ps, logic [2:0] r);
    cyc(1, md, ps, 16'd0, 0, 2'd3, 0, 3'd7, 16'd0, r);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mp[i] = 16'h0000;
    msp = 16'h0000; moff = 16'h0000; mmod = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state via read port
    for (int r = 0; r < 8; r++) cyc(0, 3'd0, 2'd0, 16'd0, 0, 2'd3, 0, 3'd7, 16'd0, 3'(r));

    // R6 upper wrap on P0: modulus 10, buffer 16
    wr(3'd6, 16'h0009);
    wr(3'd0, 16'h0129);
    op(3'd1, 2'd0, 3'd0);
    op(3'd0, 2'd0, 3'd0);
    check("R6 upper wrap literal", rd, 16'h0120);
    // R6 lower wrap
    op(3'd2, 2'd0, 3'd0);
    op(3'd0, 2'd0, 3'd0);
    check("R6 lower wrap literal", rd, 16'h0129);
    // R5 P1 linear with bit15 clear, modulo with bit15 set
    wr(3'd1, 16'h0129);
    op(3'd1, 2'd1, 3'd1);
    op(3'd0, 2'd1, 3'd1);
    check("R5 P1 linear literal", rd, 16'h012A);
    wr(3'd6, 16'h8009);
    wr(3'd1, 16'h0129);
    op(3'd1, 2'd1, 3'd1);
    op(3'd0, 2'd1, 3'd1);
    check("R5 P1 modulo literal", rd, 16'h0120);
    // R4/R6 post-offset wrap
    wr(3'd5, 16'h0004);
    wr(3'd0, 16'h0127);
    op(3'd3, 2'd0, 3'd0);
    op(3'd0, 2'd0, 3'd0);
    check("R4 post-offset wrap literal", rd, 16'h0121);
    // R7 P2, P3 linear under modulo modifier
    wr(3'd2, 16'h0129);
    op(3'd1, 2'd2, 3'd2);
    op(3'd0, 2'd2, 3'd2);
    check("R7 P2 linear literal", rd, 16'h012A);
    // R8 dual read, R9 illegal forms
    wr(3'd3, 16'hFFFF);
    cyc(1, 3'd0, 2'd0, 16'd0, 1, 2'd3, 0, 3'd7, 16'd0, 3'd3);
    cyc(1, 3'd1, 2'd3, 16'd0, 1, 2'd3, 0, 3'd7, 16'd0, 3'd3);
    cyc(1, 3'd1, 2'd1, 16'd0, 1, 2'd2, 0, 3'd7, 16'd0, 3'd1);
    cyc(1, 3'd6, 2'd0, 16'd0, 1, 2'd3, 0, 3'd7, 16'd0, 3'd4);
    op(3'd0, 2'd0, 3'd3);
    check("R8 P3 wrap literal", rd, 16'h0000);
    // R10 stack modes with modulo modifier present
    wr(3'd4, 16'h0000);
    op(3'd6, 2'd0, 3'd4);
    op(3'd7, 2'd0, 3'd4);
    // R2 write beats same-cycle update
    cyc(1, 3'd1, 2'd0, 16'd0, 0, 2'd3, 1, 3'd0, 16'h5555, 3'd0);
    op(3'd0, 2'd0, 3'd0);
    check("R2 write priority literal", rd, 16'h5555);
    // R3 indexed displacement wrap
    cyc(1, 3'd5, 2'd0, 16'hB000, 0, 2'd3, 0, 3'd7, 16'd0, 3'd0);

    // Random phase
    begin
      int seed;
      logic [15:0] mods [0:5];
      seed = 1234;
      void'($urandom(seed));
      mods[0] = 16'hFFFF; mods[1] = 16'h0009; mods[2] = 16'h8009;
      mods[3] = 16'h000F; mods[4] = 16'h8003; mods[5] = 16'h0000;
      for (int k = 0; k < 3000; k++) begin
        bit w, du;
        logic [2:0] a;
        logic [15:0] d;
        w = ($urandom % 6) == 0;
        a = 3'($urandom % 8);
        d = 16'($urandom);
        if (a == 3'd6) d = mods[$urandom % 6];
        if (a == 3'd5) d = 16'($signed(5'($urandom)));
        du = ($urandom % 6) == 0;
        cyc(($urandom % 8) != 0, 3'($urandom), 2'($urandom), 16'($urandom),
            du, (($urandom % 5) == 0) ? 2'($urandom) : 2'd3,
            w, a, d, 3'($urandom));
      end
    end
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule